// File: doc/BRIEF.md
# Configurable Trigger Match Unit

This block watches a probe bus of build-time width and decides on every clock whether the current sample meets a pattern that is loaded while the chip runs. The kind of comparison is fixed when the unit is built, by a numeric type code. The six codes are: 0 for a per-bit level compare, 1 for that compare plus edge terms, 2 for a whole-bus magnitude compare, 3 for that compare plus edge terms, 4 for a window compare, and 5 for that compare plus edge terms. A unit wired to a set of unrelated signals only has meaning with per-bit compares. For such a unit the build reduces the type to its edge bit.

The unit has two outputs, both driven from flops. The raw strobe reports the compare result for the sample taken one clock earlier. The counted strobe asserts once a programmed number of raw events has occurred. It then stays high until the unit is re-armed. With a counter width of zero there is no counter, and the first event fires the counted strobe.

The probe is sampled on every clock. There is no valid or ready pair, because a monitor must never stall the bus it observes, so no back-pressure exists. All configuration pins are plain levels. The `arm` input is a one-cycle pulse.

Top module: `trig_match_unit`

## Requirements
- R1: While `rst_n` is low, `match_raw` and `match_count` are 0, the occurrence count is cleared, and the stored previous sample is cleared.
- R2: Per-bit compare: a sample matches when every bit with `cfg_care`=1 equals the same bit of `cfg_value`. Bits with `cfg_care`=0 are don't-care. `match_raw` shows the result for the sample of the previous clock.
- R3: In an edge type, a bit with `cfg_rise`=1 needs a 0-to-1 change from the previous sample, and a bit with `cfg_fall`=1 needs a 1-to-0 change. A bit with both flags accepts either change. No edge-flagged bit can be met by the first sample after reset. In an edge type with the per-bit compare, edge-flagged bits are excluded from the level compare. Types without edges ignore both flag vectors.
- R4: Magnitude compare: with a = probe & `cfg_care` and b = `cfg_value` & `cfg_care`, `cfg_op` selects the test, treating both values as unsigned. The encodings are 0 for a==b, 1 for a!=b, 2 for a>b, and 3 for a<b.
- R5: Window compare: the inside condition is `cfg_value` <= probe <= `cfg_high`, unsigned and inclusive. The result is that condition when `cfg_negate`=0 and its inverse when `cfg_negate`=1. `cfg_care` is not used.
- R6: In the edge types 3 and 5, an event needs the level, magnitude or window result and every edge term to hold in the same sample.
- R7: When `GROUPED`=1, the unit behaves as type (`MATCH_TYPE` mod 2). For example, a type-2 build compares per bit and ignores `cfg_op`.
- R8: When `CNT_W`=0, `match_count` rises on the same edge as the first `match_raw` after arming and holds.
- R9: When `CNT_W`>0, `match_count` rises on the same edge as the `match_raw` of the N-th event since arming. N is `cfg_target`, and a target of 0 counts as 1. `match_count` then holds, and further events are not counted.
- R10: An `arm` pulse clears the count and `match_count` on the next edge. An event in the `arm` cycle still shows on `match_raw` but is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| probe | input | WIDTH | Observed bus, sampled every clock |
| cfg_value | input | WIDTH | Pattern value; low bound in window mode |
| cfg_care | input | WIDTH | Per-bit compare enable |
| cfg_high | input | WIDTH | High bound in window mode |
| cfg_rise | input | WIDTH | Per-bit rising-edge requirement |
| cfg_fall | input | WIDTH | Per-bit falling-edge requirement |
| cfg_op | input | 2 | Magnitude test select |
| cfg_negate | input | 1 | Invert window result |
| cfg_target | input | max(CNT_W,1) | Occurrences required before counted strobe |
| arm | input | 1 | Re-arm pulse |
| match_raw | output | 1 | Registered per-sample match |
| match_count | output | 1 | Sticky counted match |

## Verification
The re-arm pulse and a matching sample can arrive in the same clock. The raw path must still report that sample, while the counter must discard it. The bench drives `arm` together with a matching probe value. It checks that `match_raw` is 1 and `match_count` is 0 on the next cycle. It then sets a target of two and confirms that the strobe rises only on the second later event, which proves the event in the arm cycle was not counted.

// File: rtl/tmu_pkg.sv
package tmu_pkg;

  typedef enum logic [1:0] {
    CMP_EQ = 2'd0,
    CMP_NE = 2'd1,
    CMP_GT = 2'd2,
    CMP_LT = 2'd3
  } cmp_op_e;

  localparam int unsigned KIND_BITWISE = 0;
  localparam int unsigned KIND_MAGN    = 1;
  localparam int unsigned KIND_WINDOW  = 2;

  // Reduce the requested type to what the unit may build.
  function automatic int unsigned effective_type(input int unsigned req, input bit grouped);
    int unsigned t;
    t = (req > 5) ? 0 : req;
    if (grouped) t = t % 2;
    return t;
  endfunction

  function automatic int unsigned kind_of(input int unsigned t);
    return t / 2;
  endfunction

  function automatic bit edges_of(input int unsigned t);
    return (t % 2) == 1;
  endfunction

endpackage

// File: rtl/tmu_edge_track.sv
module tmu_edge_track #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] probe,
  input  logic [WIDTH-1:0] rise_sel,
  input  logic [WIDTH-1:0] fall_sel,
  output logic             edge_ok
);

  logic [WIDTH-1:0] prev_q;
  logic             hist_q;
  logic [WIDTH-1:0] went_up;
  logic [WIDTH-1:0] went_down;
  logic [WIDTH-1:0] bit_ok;
  logic [WIDTH-1:0] any_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      hist_q <= 1'b0;
    end else begin
      prev_q <= probe;
      hist_q <= 1'b1;
    end
  end

  always_comb begin
    went_up   = probe & ~prev_q;
    went_down = ~probe & prev_q;
    any_sel   = rise_sel | fall_sel;
    bit_ok    = ~any_sel | (rise_sel & went_up) | (fall_sel & went_down);
    // without history no flagged bit may pass
    edge_ok   = (&bit_ok) & (hist_q | ~(|any_sel));
  end

endmodule

// File: rtl/tmu_level_cmp.sv
module tmu_level_cmp
  import tmu_pkg::*;
#(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned KIND  = 0
) (
  input  logic [WIDTH-1:0] probe,
  input  logic [WIDTH-1:0] value,
  input  logic [WIDTH-1:0] care,
  input  logic [WIDTH-1:0] high,
  input  logic             negate,
  input  logic [1:0]       op,
  output logic             level_ok
);

  generate
    if (KIND == KIND_WINDOW) begin : g_window
      logic at_or_above_low;
      logic at_or_below_high;
      logic unused_win;
      assign at_or_above_low  = (probe >= value);
      assign at_or_below_high = (probe <= high);
      assign level_ok   = (at_or_above_low & at_or_below_high) ^ negate;
      assign unused_win = ^{care, op};
    end else if (KIND == KIND_MAGN) begin : g_magn
      logic [WIDTH-1:0] lhs;
      logic [WIDTH-1:0] rhs;
      cmp_op_e          sel;
      logic             unused_mag;
      assign unused_mag = ^{high, negate};
      always_comb begin
        lhs = probe & care;
        rhs = value & care;
        sel = cmp_op_e'(op);
        case (sel)
          CMP_EQ:  level_ok = (lhs == rhs);
          CMP_NE:  level_ok = (lhs != rhs);
          CMP_GT:  level_ok = (lhs > rhs);
          CMP_LT:  level_ok = (lhs < rhs);
          default: level_ok = 1'b0;
        endcase
      end
    end else begin : g_bitwise
      logic unused_bw;
      assign level_ok  = (((probe ^ value) & care) == '0);
      assign unused_bw = ^{high, negate, op};
    end
  endgenerate

endmodule

// File: rtl/tmu_occurrence.sv
module tmu_occurrence #(
  parameter int unsigned CNT_W = 0
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                hit,
  input  logic                                arm,
  input  logic [((CNT_W > 0) ? CNT_W : 1)-1:0] target,
  output logic                                fired
);

  logic done_q;

  generate
    if (CNT_W == 0) begin : g_first
      logic unused_tgt;
      assign unused_tgt = ^target;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      done_q <= 1'b0;
        else if (arm)    done_q <= 1'b0;
        else if (hit)    done_q <= 1'b1;
      end
    end else begin : g_count
      logic [CNT_W-1:0] cnt_q;
      logic [CNT_W:0]   need;
      logic [CNT_W:0]   next_cnt;
      assign need     = (target == '0) ? {{CNT_W{1'b0}}, 1'b1} : {1'b0, target};
      assign next_cnt = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q  <= '0;
          done_q <= 1'b0;
        end else if (arm) begin
          cnt_q  <= '0;
          done_q <= 1'b0;
        end else if (hit && !done_q) begin
          cnt_q <= next_cnt[CNT_W-1:0];
          if (next_cnt >= need) done_q <= 1'b1;
        end
      end
    end
  endgenerate

  assign fired = done_q;

endmodule

// File: rtl/trig_match_unit.sv
module trig_match_unit
  import tmu_pkg::*;
#(
  parameter int unsigned WIDTH      = 16,
  parameter int unsigned MATCH_TYPE = 0,
  parameter int unsigned GROUPED    = 0,
  parameter int unsigned CNT_W      = 0
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [WIDTH-1:0]                    probe,
  input  logic [WIDTH-1:0]                    cfg_value,
  input  logic [WIDTH-1:0]                    cfg_care,
  input  logic [WIDTH-1:0]                    cfg_high,
  input  logic [WIDTH-1:0]                    cfg_rise,
  input  logic [WIDTH-1:0]                    cfg_fall,
  input  logic [1:0]                          cfg_op,
  input  logic                                cfg_negate,
  input  logic [((CNT_W > 0) ? CNT_W : 1)-1:0] cfg_target,
  input  logic                                arm,
  output logic                                match_raw,
  output logic                                match_count
);

  localparam int unsigned EFF_TYPE = effective_type(MATCH_TYPE, GROUPED != 0);
  localparam int unsigned KIND     = kind_of(EFF_TYPE);
  localparam bit          EDGES    = edges_of(EFF_TYPE);

  logic [WIDTH-1:0] care_eff;
  logic             level_ok;
  logic             edge_ok;
  logic             hit;
  logic             raw_q;

  generate
    if (EDGES) begin : g_edges
      tmu_edge_track #(.WIDTH(WIDTH)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .probe    (probe),
        .rise_sel (cfg_rise),
        .fall_sel (cfg_fall),
        .edge_ok  (edge_ok)
      );
      if (KIND == KIND_BITWISE) begin : g_mask_edges
        assign care_eff = cfg_care & ~(cfg_rise | cfg_fall);
      end else begin : g_keep_care
        assign care_eff = cfg_care;
      end
    end else begin : g_no_edges
      logic unused_flags;
      assign unused_flags = ^{cfg_rise, cfg_fall};
      assign edge_ok      = 1'b1;
      assign care_eff     = cfg_care;
    end
  endgenerate

  tmu_level_cmp #(.WIDTH(WIDTH), .KIND(KIND)) u_level (
    .probe    (probe),
    .value    (cfg_value),
    .care     (care_eff),
    .high     (cfg_high),
    .negate   (cfg_negate),
    .op       (cfg_op),
    .level_ok (level_ok)
  );

  assign hit = level_ok & edge_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= 1'b0;
    else        raw_q <= hit;
  end

  tmu_occurrence #(.CNT_W(CNT_W)) u_occ (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit    (hit),
    .arm    (arm),
    .target (cfg_target),
    .fired  (match_count)
  );

  assign match_raw = raw_q;

endmodule

// File: rtl/tmu_checker.sv
module tmu_checker
  import tmu_pkg::*;
#(
  parameter int unsigned WIDTH      = 16,
  parameter int unsigned MATCH_TYPE = 0,
  parameter int unsigned GROUPED    = 0,
  parameter int unsigned CNT_W      = 0
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] probe,
  input logic [WIDTH-1:0] cfg_value,
  input logic [WIDTH-1:0] cfg_care,
  input logic [WIDTH-1:0] cfg_high,
  input logic             cfg_negate,
  input logic             arm,
  input logic             match_raw,
  input logic             match_count
);

  localparam int unsigned EFF = effective_type(MATCH_TYPE, GROUPED != 0);

  logic unused_chk;
  assign unused_chk = ^{probe, cfg_value, cfg_care, cfg_high, cfg_negate};

  // R10: re-arm empties the counted strobe
  p_arm_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> !match_count);

  // R9: counted strobe is sticky until re-arm
  p_count_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (match_count && !arm) |=> match_count);

  // R9: counted strobe only rises alongside a raw event
  p_count_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_count) |-> match_raw);

  generate
    if (EFF == 0) begin : g_bitwise_chk
      // R2: per-bit compare seen one cycle later
      p_bitwise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (match_raw == $past(((probe ^ cfg_value) & cfg_care) == '0)));
    end
    if (EFF == 4) begin : g_window_chk
      // R5: inclusive window with optional inversion
      p_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (match_raw == $past(((probe >= cfg_value) && (probe <= cfg_high)) ^ cfg_negate)));
    end
    if (CNT_W == 0) begin : g_first_chk
      // R8: first event fires the counted strobe
      p_first_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (match_raw && !$past(arm)) |-> match_count);
    end
  endgenerate

endmodule

bind trig_match_unit tmu_checker #(
  .WIDTH(WIDTH), .MATCH_TYPE(MATCH_TYPE), .GROUPED(GROUPED), .CNT_W(CNT_W)
) u_tmu_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .probe       (probe),
  .cfg_value   (cfg_value),
  .cfg_care    (cfg_care),
  .cfg_high    (cfg_high),
  .cfg_negate  (cfg_negate),
  .arm         (arm),
  .match_raw   (match_raw),
  .match_count (match_count)
);

// File: tb/trig_match_unit_test.sv
module trig_match_unit_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] probe = 8'h00;
  logic [7:0] cfg_value = 8'h00;
  logic [7:0] cfg_care = 8'h00;
  logic [7:0] cfg_high = 8'h00;
  logic [7:0] cfg_rise = 8'h00;
  logic [7:0] cfg_fall = 8'h00;
  logic [1:0] cfg_op = 2'd0;
  logic       cfg_negate = 1'b0;
  logic [2:0] tgt3 = 3'd0;
  logic [0:0] tgt1 = 1'b0;
  logic       arm = 1'b0;

  logic raw_m, cnt_m, raw_r, cnt_r, raw_g, cnt_g;
  int   n_checks = 0;
  int   n_err = 0;

  always #2 clk = ~clk;

  // magnitude compare with edges, 3-bit counter
  trig_match_unit #(.WIDTH(8), .MATCH_TYPE(3), .GROUPED(0), .CNT_W(3)) uut (
    .clk(clk), .rst_n(rst_n), .probe(probe), .cfg_value(cfg_value), .cfg_care(cfg_care),
    .cfg_high(cfg_high), .cfg_rise(cfg_rise), .cfg_fall(cfg_fall), .cfg_op(cfg_op),
    .cfg_negate(cfg_negate), .cfg_target(tgt3), .arm(arm),
    .match_raw(raw_m), .match_count(cnt_m));

  // window compare with edges, no counter
  trig_match_unit #(.WIDTH(8), .MATCH_TYPE(5), .GROUPED(0), .CNT_W(0)) u_rng (
    .clk(clk), .rst_n(rst_n), .probe(probe), .cfg_value(cfg_value), .cfg_care(cfg_care),
    .cfg_high(cfg_high), .cfg_rise(cfg_rise), .cfg_fall(cfg_fall), .cfg_op(cfg_op),
    .cfg_negate(cfg_negate), .cfg_target(tgt1), .arm(arm),
    .match_raw(raw_r), .match_count(cnt_r));

  // grouped build asking for type 2, must act as type 0
  trig_match_unit #(.WIDTH(8), .MATCH_TYPE(2), .GROUPED(1), .CNT_W(0)) u_grp (
    .clk(clk), .rst_n(rst_n), .probe(probe), .cfg_value(cfg_value), .cfg_care(cfg_care),
    .cfg_high(cfg_high), .cfg_rise(cfg_rise), .cfg_fall(cfg_fall), .cfg_op(cfg_op),
    .cfg_negate(cfg_negate), .cfg_target(tgt1), .arm(arm),
    .match_raw(raw_g), .match_count(cnt_g));

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] p);
    probe = p;
    @(negedge clk);
  endtask

  task automatic arm_pulse(input logic [7:0] p);
    arm = 1'b1;
    probe = p;
    @(negedge clk);
    arm = 1'b0;
  endtask

  task automatic t_reset;
    cfg_rise = 8'h01; cfg_care = 8'h00; cfg_op = 2'd0; probe = 8'h01;
    repeat (3) @(negedge clk);
    chk("R1", "raw in reset", raw_m, 1'b0);
    chk("R1", "count in reset", cnt_m, 1'b0);
    chk("R1", "window raw in reset", raw_r, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R3", "first sample cannot meet rise", raw_m, 1'b0);
  endtask

  task automatic t_bitwise;
    cfg_value = 8'hA5; cfg_care = 8'hF0; cfg_op = 2'd1; cfg_rise = 8'h01; cfg_fall = 8'h00;
    arm_pulse(8'h00);
    drive(8'hA3);
    chk("R2", "masked nibble match", raw_g, 1'b1);
    chk("R7", "grouped type2 acts per bit", raw_g, 1'b1);
    chk("R8", "first event fires count", cnt_g, 1'b1);
    drive(8'h35);
    chk("R2", "upper nibble mismatch", raw_g, 1'b0);
    chk("R8", "count holds", cnt_g, 1'b1);
    arm_pulse(8'h35);
    chk("R10", "arm clears count", cnt_g, 1'b0);
  endtask

  task automatic t_magnitude;
    cfg_rise = 8'h00; cfg_fall = 8'h00; cfg_care = 8'hFF; cfg_value = 8'h40;
    cfg_op = 2'd2; drive(8'h41); chk("R4", "gt 41>40", raw_m, 1'b1);
    drive(8'h40); chk("R4", "gt 40>40", raw_m, 1'b0);
    cfg_op = 2'd3; drive(8'h3F); chk("R4", "lt 3F<40", raw_m, 1'b1);
    drive(8'h40); chk("R4", "lt 40<40", raw_m, 1'b0);
    cfg_op = 2'd0; drive(8'h40); chk("R4", "eq", raw_m, 1'b1);
    cfg_op = 2'd1; drive(8'h40); chk("R4", "ne equal", raw_m, 1'b0);
    drive(8'h41); chk("R4", "ne differ", raw_m, 1'b1);
    cfg_care = 8'h0F; cfg_op = 2'd0;
    drive(8'h70); chk("R4", "masked eq", raw_m, 1'b1);
    drive(8'h71); chk("R4", "masked eq miss", raw_m, 1'b0);
  endtask

  task automatic t_edges;
    cfg_care = 8'h00; cfg_op = 2'd0; cfg_value = 8'h00;
    cfg_rise = 8'h01; cfg_fall = 8'h00;
    drive(8'h00); drive(8'h01); chk("R3", "rise seen", raw_m, 1'b1);
    drive(8'h01); chk("R3", "steady high no rise", raw_m, 1'b0);
    cfg_rise = 8'h00; cfg_fall = 8'h02;
    drive(8'h02); drive(8'h00); chk("R3", "fall seen", raw_m, 1'b1);
    cfg_rise = 8'h04; cfg_fall = 8'h04;
    drive(8'h04); chk("R3", "either edge up", raw_m, 1'b1);
    drive(8'h00); chk("R3", "either edge down", raw_m, 1'b1);
    drive(8'h00); chk("R3", "either edge none", raw_m, 1'b0);
    cfg_care = 8'hFF; cfg_value = 8'h81; cfg_rise = 8'h01; cfg_fall = 8'h00;
    drive(8'h80); drive(8'h81); chk("R6", "edge and level", raw_m, 1'b1);
    drive(8'h00); drive(8'h01); chk("R6", "edge without level", raw_m, 1'b0);
  endtask

  task automatic t_window;
    cfg_rise = 8'h00; cfg_fall = 8'h00; cfg_care = 8'h00;
    cfg_value = 8'h10; cfg_high = 8'h20; cfg_negate = 1'b0;
    drive(8'h10); chk("R5", "low bound inclusive", raw_r, 1'b1);
    drive(8'h20); chk("R5", "high bound inclusive", raw_r, 1'b1);
    drive(8'h0F); chk("R5", "below low", raw_r, 1'b0);
    drive(8'h21); chk("R5", "above high", raw_r, 1'b0);
    cfg_negate = 1'b1;
    drive(8'h0F); chk("R5", "negate outside", raw_r, 1'b1);
    drive(8'h20); chk("R5", "negate inside", raw_r, 1'b0);
    cfg_negate = 1'b0; cfg_high = 8'hFF; cfg_rise = 8'h80;
    drive(8'h10); chk("R6", "window no edge", raw_r, 1'b0);
    drive(8'h90); chk("R6", "window with rise", raw_r, 1'b1);
    drive(8'h91); chk("R6", "window edge gone", raw_r, 1'b0);
    cfg_rise = 8'h00;
  endtask

  task automatic t_counter;
    cfg_care = 8'hFF; cfg_value = 8'h55; cfg_op = 2'd0; cfg_rise = 8'h00; cfg_fall = 8'h00;
    tgt3 = 3'd3;
    arm_pulse(8'h00);
    drive(8'h55); chk("R9", "event 1 raw", raw_m, 1'b1); chk("R9", "event 1 count", cnt_m, 1'b0);
    drive(8'h00);
    drive(8'h55); chk("R9", "event 2 count", cnt_m, 1'b0);
    drive(8'h55); chk("R9", "event 3 count", cnt_m, 1'b1);
    drive(8'h00); chk("R9", "count sticky", cnt_m, 1'b1);
    tgt3 = 3'd2;
    arm_pulse(8'h55);
    chk("R10", "arm cycle raw", raw_m, 1'b1);
    chk("R10", "arm cycle count", cnt_m, 1'b0);
    drive(8'h55); chk("R10", "arm event not counted", cnt_m, 1'b0);
    drive(8'h55); chk("R9", "target 2 reached", cnt_m, 1'b1);
    arm_pulse(8'h00);
    tgt3 = 3'd0;
    drive(8'h55); chk("R9", "target 0 acts as 1", cnt_m, 1'b1);
    tgt3 = 3'd7;
    arm_pulse(8'h00);
    for (int i = 0; i < 6; i++) drive(8'h55);
    chk("R9", "six of seven", cnt_m, 1'b0);
    drive(8'h55); chk("R9", "seventh fires", cnt_m, 1'b1);
    drive(8'h55); chk("R9", "saturated hold", cnt_m, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    n_checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    t_reset();
    t_bitwise();
    t_magnitude();
    t_edges();
    t_window();
    t_counter();
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule